// File: doc/BRIEF.md
# Parity Product Code Group Receiver

This block sits at the receiving end of a link that protects data with a two-dimensional parity product code. Data moves in flits. Each flit carries `DATA_W` data bits and one even-parity bit. A group is `GROUP_FLITS` data flits followed by one parity flit. The parity flit is the bitwise XOR of those data flits, so it also has even parity itself. The receiver stores the whole group in a buffer. While it stores, it keeps two running values: the per-flit parity failures, one bit for each row, and the column parity, one bit for each bit index. When the parity flit arrives, the receiver uses these two values to choose one of four outcomes.

If both values are clean, the data flits are released unchanged. If exactly one row and exactly one column fail, the bit at their crossing is inverted as the flits are read out. If no row fails but some columns do, a flit hides an even number of flips. The receiver then asks the transmitter to resend those columns, and only those bit columns are overwritten with the returned flits. Every other detected pattern produces a go-back request, and the whole group is replaced by the next one that arrives. After any retransmission the checks run again. A second failure always produces a go-back and is never corrected.

Top module: `ppc_rx_corrector`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_last`, `req_row` and `req_goback` are low.
- R2: A flit holds data in bits [DATA_W-1:0] and even parity over the data in bit DATA_W. The parity flit is the XOR of the group's data flits. When a group has no failing row and no failing column, its data flits are output unchanged and in order. They appear on `out_valid` for GROUP_FLITS consecutive cycles that begin in the second cycle after the parity flit is accepted, and `out_last` is high only on the final one.
- R3: When exactly one flit fails its row parity and exactly one column fails, the bit at that crossing is inverted on output. If the crossing is a flit's parity bit or lies inside the parity flit, the output data is unchanged.
- R4: When no row fails but at least one column fails, `req_row` is high for one cycle, in the cycle after the parity flit is accepted. In that cycle `req_mask` equals the column syndrome: bit j for data bit j, and bit DATA_W for the parity column. No data is output for the group.
- R5: After a row request, the next GROUP_FLITS+1 accepted flits overwrite only the bit columns set in `req_mask`, and every other stored bit is kept. If the merged group then checks clean, it is output as in R2.
- R6: After any retransmission, whether by row or go-back, a merged group that shows any row or column failure raises `req_goback` and is not corrected.
- R7: On a first reception, any other detected pattern raises `req_goback` for one cycle, in the cycle after the parity flit is accepted. Such patterns include two or more failing rows, or one failing row together with zero or several failing columns. The next GROUP_FLITS+1 accepted flits then replace the stored group entirely.
- R8: Four flips at the corners of a rectangle in (flit, bit) space leave both syndromes clean. The group is output as received and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A flit is presented on `in_flit` |
| in_flit | input | DATA_W+1 | Incoming flit: parity bit on top, data below |
| out_valid | output | 1 | `out_data` carries a released data flit |
| out_data | output | DATA_W | Corrected data flit |
| out_last | output | 1 | Final data flit of the group |
| req_row | output | 1 | One-cycle request to resend the columns in `req_mask` |
| req_mask | output | DATA_W+1 | Failing bit indexes named by the row request |
| req_goback | output | 1 | One-cycle request to resend the whole group |

## Verification
The assertions assume that the transmitter presents flits only while the receiver is collecting. It stays silent during the decision cycle and during the output burst, and it answers every request with a complete group. The stimulus keeps to this. It sends a new group only after the final `out_last` cycle, or right after a request pulse, and it always sends exactly GROUP_FLITS+1 flits. Under these conditions, a burst's length, its end marker, and the separation between requests and output follow from the receiver alone.

// File: rtl/ppc_rx_pkg.sv
package ppc_rx_pkg;

   typedef enum logic [1:0] {
      ACT_PASS   = 2'd0,
      ACT_FIX    = 2'd1,
      ACT_ROW    = 2'd2,
      ACT_GOBACK = 2'd3
   } ppc_act_e;

   typedef enum logic {
      ST_COLLECT = 1'b0,
      ST_DRAIN   = 1'b1
   } ppc_state_e;

endpackage

// File: rtl/ppc_group_buf.sv
module ppc_group_buf #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 5,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_idx,
   input  logic [DATA_W:0]   wr_flit,
   input  logic [DATA_W:0]   wr_mask,
   output logic [DATA_W:0]   wr_merged,
   input  logic [AW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W:0] mem [DEPTH];

   // masked columns take new bits, the rest keep what is stored
   assign wr_merged = (mem[wr_idx] & ~wr_mask) | (wr_flit & wr_mask);
   assign rd_data   = mem[rd_idx][DATA_W-1:0];

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (wr_en && (wr_idx == AW'(e))) begin
            mem[e] <= wr_merged;
         end
      end
   end

endmodule

// File: rtl/ppc_syndrome.sv
module ppc_syndrome #(
   parameter int FLIT_W = 9,
   parameter int FLITS  = 5,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [AW-1:0]     idx,
   input  logic [FLIT_W-1:0] flit,
   output logic [FLITS-1:0]  row_fail,
   output logic [FLIT_W-1:0] col_syn
);

   logic row_bad;
   assign row_bad = ^flit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_fail <= '0;
         col_syn  <= '0;
      end else if (en) begin
         if (idx == '0) begin
            col_syn  <= flit;
            row_fail <= FLITS'(row_bad);
         end else begin
            col_syn       <= col_syn ^ flit;
            row_fail[idx] <= row_bad;
         end
      end
   end

endmodule

// File: rtl/ppc_decide.sv
module ppc_decide
   import ppc_rx_pkg::*;
#(
   parameter int FLIT_W = 9,
   parameter int FLITS  = 5,
   parameter int AW     = 3
) (
   input  logic [FLITS-1:0]  row_fail,
   input  logic [FLIT_W-1:0] col_syn,
   input  logic              retry,
   output ppc_act_e          act,
   output logic [AW-1:0]     fix_row
);

   logic row_none, col_none, row_one, col_one;

   assign row_none = (row_fail == '0);
   assign col_none = (col_syn == '0);
   assign row_one  = ($countones(row_fail) == 1);
   assign col_one  = ($countones(col_syn) == 1);

   always_comb begin
      fix_row = '0;
      for (int r = 0; r < FLITS; r++) begin
         if (row_fail[r]) fix_row = AW'(r);
      end
   end

   always_comb begin
      if (row_none && col_none)            act = ACT_PASS;
      else if (retry)                      act = ACT_GOBACK;
      else if (row_one && col_one)         act = ACT_FIX;
      else if (row_none)                   act = ACT_ROW;
      else                                 act = ACT_GOBACK;
   end

endmodule

// File: rtl/ppc_rx_corrector.sv
module ppc_rx_corrector
   import ppc_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int GROUP_FLITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W:0]   in_flit,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              req_row,
   output logic [DATA_W:0]   req_mask,
   output logic              req_goback
);

   localparam int FLIT_W    = DATA_W + 1;
   localparam int BUF_DEPTH = GROUP_FLITS + 1;
   localparam int IDX_W     = $clog2(BUF_DEPTH);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("ppc_rx_corrector: DATA_W must be at least 2");
      end
      if (GROUP_FLITS < 2) begin : g_bad_group
         $error("ppc_rx_corrector: GROUP_FLITS must be at least 2");
      end
   endgenerate

   ppc_state_e        state_q;
   logic [IDX_W-1:0]  wr_cnt_q, rd_cnt_q, fix_row_q;
   logic              eval_q, retry_q, fix_en_q;
   logic [FLIT_W-1:0] wmask_q;
   logic [DATA_W-1:0] fix_mask_q;

   logic              accept, last_in;
   logic [FLIT_W-1:0] merged, col_syn;
   logic [BUF_DEPTH-1:0] row_fail;
   logic [DATA_W-1:0] rd_data, rd_fix;
   ppc_act_e          act;
   logic [IDX_W-1:0]  fix_row;

   assign accept  = in_valid && (state_q == ST_COLLECT) && !eval_q;
   assign last_in = accept && (wr_cnt_q == IDX_W'(BUF_DEPTH - 1));

   ppc_group_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (BUF_DEPTH),
      .AW     (IDX_W)
   ) u_buf (
      .clk       (clk),
      .wr_en     (accept),
      .wr_idx    (wr_cnt_q),
      .wr_flit   (in_flit),
      .wr_mask   (wmask_q),
      .wr_merged (merged),
      .rd_idx    (rd_cnt_q),
      .rd_data   (rd_data)
   );

   ppc_syndrome #(
      .FLIT_W (FLIT_W),
      .FLITS  (BUF_DEPTH),
      .AW     (IDX_W)
   ) u_syn (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (accept),
      .idx      (wr_cnt_q),
      .flit     (merged),
      .row_fail (row_fail),
      .col_syn  (col_syn)
   );

   ppc_decide #(
      .FLIT_W (FLIT_W),
      .FLITS  (BUF_DEPTH),
      .AW     (IDX_W)
   ) u_dec (
      .row_fail (row_fail),
      .col_syn  (col_syn),
      .retry    (retry_q),
      .act      (act),
      .fix_row  (fix_row)
   );

   assign rd_fix = (fix_en_q && (rd_cnt_q == fix_row_q)) ? fix_mask_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_COLLECT;
         wr_cnt_q   <= '0;
         rd_cnt_q   <= '0;
         eval_q     <= 1'b0;
         retry_q    <= 1'b0;
         wmask_q    <= '1;
         fix_en_q   <= 1'b0;
         fix_row_q  <= '0;
         fix_mask_q <= '0;
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_last   <= 1'b0;
         req_row    <= 1'b0;
         req_mask   <= '0;
         req_goback <= 1'b0;
      end else begin
         out_valid  <= 1'b0;
         out_last   <= 1'b0;
         req_row    <= 1'b0;
         req_goback <= 1'b0;

         if (accept) begin
            wr_cnt_q <= last_in ? '0 : wr_cnt_q + 1'b1;
            eval_q   <= last_in;
         end

         if (eval_q) begin
            eval_q <= 1'b0;
            unique case (act)
               ACT_PASS, ACT_FIX: begin
                  state_q    <= ST_DRAIN;
                  rd_cnt_q   <= '0;
                  fix_en_q   <= (act == ACT_FIX);
                  fix_row_q  <= fix_row;
                  fix_mask_q <= col_syn[DATA_W-1:0];
                  retry_q    <= 1'b0;
                  wmask_q    <= '1;
               end
               ACT_ROW: begin
                  req_row  <= 1'b1;
                  req_mask <= col_syn;
                  wmask_q  <= col_syn;
                  retry_q  <= 1'b1;
               end
               default: begin
                  req_goback <= 1'b1;
                  wmask_q    <= '1;
                  retry_q    <= 1'b1;
               end
            endcase
         end

         if (state_q == ST_DRAIN) begin
            out_valid <= 1'b1;
            out_data  <= rd_data ^ rd_fix;
            out_last  <= (rd_cnt_q == IDX_W'(GROUP_FLITS - 1));
            rd_cnt_q  <= rd_cnt_q + 1'b1;
            if (rd_cnt_q == IDX_W'(GROUP_FLITS - 1)) begin
               state_q <= ST_COLLECT;
            end
         end
      end
   end

endmodule

// File: rtl/ppc_rx_corrector_chk.sv
module ppc_rx_corrector_chk #(
   parameter int DATA_W      = 8,
   parameter int GROUP_FLITS = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            out_valid,
   input logic            out_last,
   input logic            req_row,
   input logic [DATA_W:0] req_mask,
   input logic            req_goback
);

   int run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= 0;
      else if (out_valid) run_q <= run_q + 1;
      else                run_q <= 0;
   end

   assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_valid && run_q == GROUP_FLITS - 1));

   assert_burst_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |=> !out_valid);

   assert_row_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_row |=> !req_row);

   assert_row_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_row |-> (req_mask != '0));

   assert_row_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_row |=> !out_valid);

   assert_goback_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_goback |=> !req_goback);

   assert_req_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_goback && (req_row || out_valid)));

endmodule

bind ppc_rx_corrector ppc_rx_corrector_chk #(
   .DATA_W      (DATA_W),
   .GROUP_FLITS (GROUP_FLITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .out_last   (out_last),
   .req_row    (req_row),
   .req_mask   (req_mask),
   .req_goback (req_goback)
);

// File: tb/ppc_rx_corrector_bench.sv
module ppc_rx_corrector_bench;

   localparam int  N       = 8;
   localparam int  M       = 4;
   localparam int  W       = N + 1;
   localparam time CLK_PER = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_flit = '0;
   logic         out_valid, out_last, req_row, req_goback;
   logic [N-1:0] out_data;
   logic [W-1:0] req_mask;

   ppc_rx_corrector #(.DATA_W(N), .GROUP_FLITS(M)) u_ppc_rx_corrector (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .req_row(req_row), .req_mask(req_mask), .req_goback(req_goback)
   );

   always #(CLK_PER/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_cmp = 0;
   int n_bad = 0;

   // scheduled expectations, keyed by cycle number
   bit           ev_valid [int];
   logic [N-1:0] ev_data  [int];
   bit           ev_last  [int];
   bit           ev_row   [int];
   logic [W-1:0] ev_mask  [int];
   bit           ev_gb    [int];
   string        ev_tag   [int];

   // reference state
   logic [W-1:0] txg   [M+1];
   logic [W-1:0] store [M+1];
   logic [N-1:0] base  [M];
   bit           m_retry = 1'b0;
   logic [W-1:0] m_mask  = '1;
   string        case_tag = "R2";

   task automatic cmp(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      string tg;
      bit ev, el, er, eg;
      ev = ev_valid.exists(cyc) ? ev_valid[cyc] : 1'b0;
      el = ev_last.exists(cyc)  ? ev_last[cyc]  : 1'b0;
      er = ev_row.exists(cyc)   ? ev_row[cyc]   : 1'b0;
      eg = ev_gb.exists(cyc)    ? ev_gb[cyc]    : 1'b0;
      tg = ev_tag.exists(cyc)   ? ev_tag[cyc]   : (rst_n ? "idle" : "R1");
      if (cyc <= 1 || !rst_n) tg = "R1";
      cmp(tg, "out_valid", int'(out_valid), int'(ev));
      cmp(tg, "out_last", int'(out_last), int'(el));
      cmp(tg, "req_row", int'(req_row), int'(er));
      cmp(tg, "req_goback", int'(req_goback), int'(eg));
      if (ev) cmp(tg, "out_data", int'(out_data), int'(ev_data[cyc]));
      if (er) cmp(tg, "req_mask", int'(req_mask), int'(ev_mask[cyc]));
   end

   function automatic logic [W-1:0] mk(logic [N-1:0] d);
      return {^d, d};
   endfunction

   task automatic build(int seed);
      logic [W-1:0] pf;
      pf = '0;
      for (int i = 0; i < M; i++) begin
         base[i] = N'(seed * 37 + i * 91 + 5);
         txg[i]  = mk(base[i]);
         pf      = pf ^ txg[i];
      end
      txg[M] = pf;
   endtask

   // sends one group, predicts the outcome, schedules it; returns 1 on a request
   task automatic send(output bit requested);
      int L, nrow, ncol, frow;
      logic [W-1:0] cp;
      string tg;
      for (int k = 0; k <= M; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_flit  = txg[k];
         store[k] = (store[k] & ~m_mask) | (txg[k] & m_mask);
         if (k == M) L = cyc + 1;
      end
      @(negedge clk);
      in_valid = 1'b0;
      cp = '0; nrow = 0; frow = 0;
      for (int k = 0; k <= M; k++) begin
         cp = cp ^ store[k];
         if (^store[k]) begin nrow++; frow = k; end
      end
      ncol = $countones(cp);
      requested = 1'b1;
      if (nrow == 0 && ncol == 0 || (!m_retry && nrow == 1 && ncol == 1)) begin
         if (nrow == 1) tg = "R3";
         else if (m_retry) tg = "R5";
         else tg = case_tag;
         for (int i = 0; i < M; i++) begin
            ev_valid[L+2+i] = 1'b1;
            ev_data[L+2+i]  = store[i][N-1:0] ^ ((nrow == 1 && i == frow) ? cp[N-1:0] : '0);
            ev_last[L+2+i]  = (i == M - 1);
            ev_tag[L+2+i]   = tg;
         end
         m_retry = 1'b0; m_mask = '1; requested = 1'b0;
      end else if (!m_retry && nrow == 0) begin
         ev_row[L+1] = 1'b1; ev_mask[L+1] = cp; ev_tag[L+1] = "R4";
         for (int i = 2; i < M + 2; i++) ev_tag[L+i] = "R4";
         m_retry = 1'b1; m_mask = cp;
      end else begin
         ev_gb[L+1] = 1'b1; ev_tag[L+1] = m_retry ? "R6" : "R7";
         m_retry = 1'b1; m_mask = '1;
      end
      if (!requested) repeat (M) @(negedge clk);
   endtask

   task automatic flip(int f, int b);
      txg[f][b] = ~txg[f][b];
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      bit rq;
      for (int k = 0; k <= M; k++) store[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: clean groups, several data patterns
      for (int s = 1; s <= 3; s++) begin build(s); send(rq); end
      build(0); send(rq);

      // R3: data bit, parity bit, parity-flit bit
      build(11); flip(2, 5); send(rq);
      build(12); flip(1, N); send(rq);
      build(13); flip(M, 3); send(rq);
      build(14); flip(0, 0); send(rq);

      // R4 then R5: hidden double flip, columns resent; bit 0 of flit 0 outside mask is ignored
      build(21); flip(1, 2); flip(1, 6); send(rq);
      build(21); flip(0, 0); send(rq);

      // R4 then R6: resent column still wrong -> go-back; R5 go-back resend clean
      build(22); flip(3, 1); flip(3, 4); send(rq);
      build(22); flip(0, 1); send(rq);
      build(22); send(rq);

      // R7: two rows, two columns; retry single flip -> R6; then clean
      build(23); flip(0, 0); flip(2, 3); send(rq);
      build(23); flip(1, 1); send(rq);
      build(23); send(rq);

      // R7: two rows, same column (column syndrome clean)
      build(24); flip(1, 2); flip(2, 2); send(rq);
      build(24); send(rq);

      // R8: rectangle goes through undetected
      case_tag = "R8";
      build(25); flip(0, 1); flip(0, 4); flip(2, 1); flip(2, 4); send(rq);
      case_tag = "R2";
      build(26); send(rq);

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule